// File: doc/BRIEF.md
# Active Priority Preemption Tracker

This block follows, for a single processor interface of an interrupt controller, which priority levels are currently in service. When an acknowledge request arrives with the identifier, 8-bit priority and group of the interrupt chosen elsewhere, the block decides whether that interrupt may preempt the work already running. If it may, the block records the interrupt's preemption level in one of two per-group level bitmaps, marks the identifier active, and raises the running priority. An end-of-interrupt request retires the most urgent level held in the bitmap of the interrupt's group. The running priority is then rebuilt from what remains in both bitmaps.

Before a priority is recorded it is coarsened by a binary point, and only the upper bits (the group priority) take part in preemption. Two binary point registers are held here: a main one and an alias used by group-1 interrupts. A common-binary-point control input makes group 1 use the main register instead. The smallest binary point is a parameter, `MIN_BPR`. It sets how many preemption levels exist and so how many 32-bit bitmap words are kept. A small controller has two states. `S_IDLE` means nothing is in service and the running priority is 0x100. `S_ACTIVE` means at least one level is held. The transition `T_GRANT` (a granted acknowledge) moves `S_IDLE` to `S_ACTIVE`. The transition `T_RETIRE_LAST` (an end-of-interrupt that leaves both bitmaps empty) moves `S_ACTIVE` back to `S_IDLE`. Every other event keeps the current state.

Top module: `apt_tracker`

## Requirements
- R1: After reset the running priority is 0x100, the main binary point equals `MIN_BPR`, the alias binary point equals `MIN_BPR+1`, no identifier is active, and no response is signalled.
- R2: The group priority of an acknowledged interrupt is its 8-bit priority ANDed with 0xFF shifted left by (binary point + 1). A binary point of 7 gives group priority 0.
- R3: A group-1 interrupt (`ack_grp`=1) uses the alias binary point when `cbpr_en` is 0 and the main binary point when `cbpr_en` is 1. A group-0 interrupt always uses the main binary point.
- R4: An acknowledge is refused when its identifier is 1020 or above, or when its 8-bit priority is greater than or equal to the running priority. A refusal returns `rsp_grant`=0 and `rsp_id`=1023 and leaves the running priority, the active flags and the bitmaps unchanged.
- R5: A granted acknowledge returns `rsp_grant`=1 and `rsp_id` equal to the request's identifier. It sets the running priority to the group priority, and it sets `active[id]` when the identifier is below `NUM_IRQ`.
- R6: An end-of-interrupt clears the lowest set level in the bitmap of the group recorded for that identifier at acknowledge. The lowest level is searched from word 0 upward. The running priority becomes (lowest level remaining in the OR of both bitmaps) shifted left by (`MIN_BPR`+1), or 0x100 if both bitmaps are empty. `active[id]` is cleared.
- R7: An end-of-interrupt is ignored when the block is in `S_IDLE` (running priority 0x100) or when its identifier is `NUM_IRQ` or above.
- R8: A binary point write keeps bits [2:0] of `bp_wdata` and raises the result to the register's minimum: `MIN_BPR` for the main register and `MIN_BPR+1` for the alias register.
- R9: When an acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge is processed and the end-of-interrupt is dropped.
- R10: Every acknowledge request produces a one-cycle `rsp_valid` pulse in the following cycle. The running priority, active flags and binary points change in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge request, one cycle |
| ack_id | input | 10 | Identifier of the pending interrupt |
| ack_prio | input | 8 | Priority of the pending interrupt |
| ack_grp | input | 1 | Group of the pending interrupt (1 = group 1) |
| eoi_req | input | 1 | End-of-interrupt request, one cycle |
| eoi_id | input | 10 | Identifier being retired |
| cbpr_en | input | 1 | Group 1 uses the main binary point |
| bpr_we | input | 1 | Write the main binary point |
| abpr_we | input | 1 | Write the alias binary point |
| bp_wdata | input | 8 | Binary point write data |
| bpr_val | output | 3 | Main binary point |
| abpr_val | output | 3 | Alias binary point |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| rsp_valid | output | 1 | Acknowledge response strobe |
| rsp_grant | output | 1 | Acknowledge accepted |
| rsp_id | output | 10 | Accepted identifier, or 1023 |
| active | output | NUM_IRQ | Per-identifier active flags |

## Verification
The assertions assume that requests are single-cycle pulses. They also assume that software nests correctly: each end-of-interrupt names the identifier of the most recently granted interrupt that is still in service. Only under that ordering is the running priority guaranteed to fall back monotonically.

The stimulus keeps to this rule except in one deliberate case. In that case a group-0 interrupt is retired while a more urgent group-1 interrupt is still in service. This shows that only the group-0 bitmap loses a bit.

The stimulus never writes binary points while an acknowledge is in flight. Identifiers out of range are used only where a requirement calls for them.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int          ID_W       = 10;
    localparam logic [9:0]  ID_NONE    = 10'd1023;
    localparam logic [9:0]  ID_LIMIT   = 10'd1020;
    localparam logic [8:0]  PRIO_IDLE  = 9'h100;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_ACTIVE = 1'b1
    } apt_state_e;

    // index of the least significant set bit of a 32-bit word (0 if none)
    function automatic logic [4:0] low_index32(input logic [31:0] w);
        logic [4:0] r;
        r = 5'd0;
        for (int b = 31; b >= 0; b--) begin
            if (w[b]) r = 5'(b);
        end
        return r;
    endfunction

endpackage

// File: rtl/apt_bp_regs.sv
module apt_bp_regs #(
    parameter int MIN_BPR = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bpr_we,
    input  logic       abpr_we,
    input  logic [2:0] wdata,
    output logic [2:0] bpr_q,
    output logic [2:0] abpr_q
);
    localparam logic [2:0] BPR_MIN  = 3'(MIN_BPR);
    localparam logic [2:0] ABPR_MIN = 3'(MIN_BPR + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpr_q  <= BPR_MIN;
            abpr_q <= ABPR_MIN;
        end else begin
            if (bpr_we)
                bpr_q <= (wdata < BPR_MIN) ? BPR_MIN : wdata;
            if (abpr_we)
                abpr_q <= (wdata < ABPR_MIN) ? ABPR_MIN : wdata;
        end
    end

    AST_BP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (bpr_q >= BPR_MIN) && (abpr_q >= ABPR_MIN)); // R8

endmodule

// File: rtl/apt_grp_prio.sv
module apt_grp_prio #(
    parameter bit HAS_GROUPS = 1'b1
) (
    input  logic [7:0] prio,
    input  logic       grp,
    input  logic       cbpr_en,
    input  logic [2:0] bpr,
    input  logic [2:0] abpr,
    output logic [7:0] gprio,
    output logic       eff_grp
);
    logic [2:0] bp_sel;
    logic [7:0] keep_mask;

    always_comb begin
        eff_grp   = HAS_GROUPS ? grp : 1'b0;
        bp_sel    = (eff_grp && !cbpr_en) ? abpr : bpr;
        keep_mask = 8'hFF << ({1'b0, bp_sel} + 4'd1);
        gprio     = prio & keep_mask;
    end

endmodule

// File: rtl/apt_level_map.sv
module apt_level_map #(
    parameter int MIN_BPR = 0,
    localparam int NLVL = 256 >> (MIN_BPR + 1),
    localparam int NW   = (NLVL + 31) / 32,
    localparam int MW   = NW * 32,
    localparam int LW   = $clog2(MW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          set_grp,
    input  logic [LW-1:0] set_lvl,
    input  logic          clr_en,
    input  logic          clr_grp,
    output logic          after_empty,
    output logic [LW-1:0] after_lvl
);
    // index 0 holds group-0 levels, index 1 holds group-1 levels
    logic [1:0][MW-1:0] map_q;
    logic [1:0][MW-1:0] map_after;
    logic [MW-1:0]      merged;
    logic [NW-1:0]      word_nz;
    logic [4:0]         word_lo [NW];

    always_comb begin
        for (int g = 0; g < 2; g++) begin
            if (clr_en && (clr_grp == (g == 1)))
                map_after[g] = map_q[g] & (map_q[g] - MW'(1));
            else
                map_after[g] = map_q[g];
        end
        merged = map_after[0] | map_after[1];
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        assign word_nz[w] = |merged[w*32 +: 32];
        assign word_lo[w] = apt_pkg::low_index32(merged[w*32 +: 32]);
    end

    always_comb begin
        after_empty = 1'b1;
        after_lvl   = '0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (word_nz[w]) begin
                after_empty = 1'b0;
                after_lvl   = LW'(w * 32) + LW'(word_lo[w]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                if (set_en && (set_grp == (g == 1)))
                    map_q[g] <= map_after[g] | (MW'(1) << set_lvl);
                else
                    map_q[g] <= map_after[g];
            end
        end
    end

    AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && (map_q[clr_grp] != '0)) |=>
        ($countones(map_q[$past(clr_grp)]) == $countones($past(map_q[clr_grp])) - 1)); // R6

endmodule

// File: rtl/apt_tracker.sv
module apt_tracker #(
    parameter int MIN_BPR    = 0,
    parameter int NUM_IRQ    = 64,
    parameter bit HAS_GROUPS = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_req,
    input  logic [9:0]         ack_id,
    input  logic [7:0]         ack_prio,
    input  logic               ack_grp,
    input  logic               eoi_req,
    input  logic [9:0]         eoi_id,
    input  logic               cbpr_en,
    input  logic               bpr_we,
    input  logic               abpr_we,
    input  logic [7:0]         bp_wdata,
    output logic [2:0]         bpr_val,
    output logic [2:0]         abpr_val,
    output logic [8:0]         run_prio,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic [9:0]         rsp_id,
    output logic [NUM_IRQ-1:0] active
);
    import apt_pkg::*;

    localparam int NLVL  = 256 >> (MIN_BPR + 1);
    localparam int NW    = (NLVL + 31) / 32;
    localparam int LW    = $clog2(NW * 32);
    localparam int SH    = MIN_BPR + 1;
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [9:0] ID_COUNT = 10'(NUM_IRQ);

    apt_state_e         state_q, state_d;
    logic [8:0]         run_q;
    logic [NUM_IRQ-1:0] act_q, grp_q;
    logic [7:0]         gprio;
    logic               eff_grp;
    logic               grant, eoi_take, eoi_grp;
    logic [IDX_W-1:0]   ack_idx, eoi_idx;
    logic               after_empty;
    logic [LW-1:0]      after_lvl;
    logic [8:0]         run_after;

    apt_bp_regs #(.MIN_BPR(MIN_BPR)) u_bp (
        .clk    (clk),
        .rst_n  (rst_n),
        .bpr_we (bpr_we),
        .abpr_we(abpr_we),
        .wdata  (bp_wdata[2:0]),
        .bpr_q  (bpr_val),
        .abpr_q (abpr_val)
    );

    apt_grp_prio #(.HAS_GROUPS(HAS_GROUPS)) u_gp (
        .prio   (ack_prio),
        .grp    (ack_grp),
        .cbpr_en(cbpr_en),
        .bpr    (bpr_val),
        .abpr   (abpr_val),
        .gprio  (gprio),
        .eff_grp(eff_grp)
    );

    apt_level_map #(.MIN_BPR(MIN_BPR)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (grant),
        .set_grp    (eff_grp),
        .set_lvl    (LW'(gprio >> SH)),
        .clr_en     (eoi_take),
        .clr_grp    (eoi_grp),
        .after_empty(after_empty),
        .after_lvl  (after_lvl)
    );

    // request decode
    always_comb begin
        ack_idx  = IDX_W'(ack_id);
        eoi_idx  = IDX_W'(eoi_id);
        grant    = ack_req && (ack_id < ID_LIMIT) && ({1'b0, ack_prio} < run_q);
        eoi_take = eoi_req && !ack_req && (state_q == S_ACTIVE) && (eoi_id < ID_COUNT);
        eoi_grp  = (eoi_id < ID_COUNT) ? grp_q[eoi_idx] : 1'b0;
        run_after = after_empty ? PRIO_IDLE : (9'(after_lvl) << SH);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (grant) state_d = S_ACTIVE;                       // T_GRANT
            S_ACTIVE: if (eoi_take && after_empty) state_d = S_IDLE;        // T_RETIRE_LAST
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and per-identifier state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= PRIO_IDLE;
            act_q     <= '0;
            grp_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_id    <= ID_NONE;
        end else begin
            rsp_valid <= ack_req;
            rsp_grant <= grant;
            if (ack_req) rsp_id <= grant ? ack_id : ID_NONE;
            if (grant) begin
                run_q <= {1'b0, gprio};
                if (ack_id < ID_COUNT) begin
                    act_q[ack_idx] <= 1'b1;
                    grp_q[ack_idx] <= eff_grp;
                end
            end else if (eoi_take) begin
                run_q          <= run_after;
                act_q[eoi_idx] <= 1'b0;
            end
        end
    end

    assign run_prio = run_q;
    assign active   = act_q;

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (run_q == PRIO_IDLE)); // R1
    AST_PRIO_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q != PRIO_IDLE) |-> (run_q[SH-1:0] == '0)); // R6
    AST_REFUSE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (rsp_id == ID_NONE)); // R4
    AST_GRANT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && grant) |=> (run_q < $past(run_q))); // R5
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> rsp_valid); // R10
    AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && eoi_req && !ack_req) |=> $stable(run_q)); // R7
    AST_EOI_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !grant && eoi_req) |=> $stable(run_q)); // R9

endmodule

// File: tb/tb_apt_tracker.sv
module tb_apt_tracker;

    localparam int NUM_IRQ = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ack_req = 1'b0;
    logic [9:0]         ack_id = '0;
    logic [7:0]         ack_prio = '0;
    logic               ack_grp = 1'b0;
    logic               eoi_req = 1'b0;
    logic [9:0]         eoi_id = '0;
    logic               cbpr_en = 1'b0;
    logic               bpr_we = 1'b0;
    logic               abpr_we = 1'b0;
    logic [7:0]         bp_wdata = '0;
    logic [2:0]         bpr_val, abpr_val;
    logic [8:0]         run_prio;
    logic               rsp_valid, rsp_grant;
    logic [9:0]         rsp_id;
    logic [NUM_IRQ-1:0] active;

    int checks = 0;
    int errors = 0;

    apt_tracker #(.MIN_BPR(0), .NUM_IRQ(NUM_IRQ), .HAS_GROUPS(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_id(ack_id),
        .ack_prio(ack_prio), .ack_grp(ack_grp), .eoi_req(eoi_req), .eoi_id(eoi_id),
        .cbpr_en(cbpr_en), .bpr_we(bpr_we), .abpr_we(abpr_we), .bp_wdata(bp_wdata),
        .bpr_val(bpr_val), .abpr_val(abpr_val), .run_prio(run_prio),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_id(rsp_id), .active(active)
    );

    always #5 clk = ~clk;

    // op codes: 0 ack, 1 eoi, 2 main bp write, 3 alias bp write, 4 cbpr level
    // entry: {op[3], id[10], data[8], grp, exp_grant, exp_run[9]}
    localparam int NV = 27;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 10'd40,   8'hA5, 1'b0, 1'b1, 9'h0A4},  // R5 R2 bp0
        {3'd0, 10'd41,   8'hA4, 1'b0, 1'b0, 9'h0A4},  // R4 equal priority
        {3'd0, 10'd42,   8'h63, 1'b1, 1'b1, 9'h060},  // R3 alias bp 1
        {3'd0, 10'd1020, 8'h00, 1'b0, 1'b0, 9'h060},  // R4 id limit
        {3'd0, 10'd43,   8'h21, 1'b0, 1'b1, 9'h020},  // R5
        {3'd1, 10'd43,   8'h00, 1'b0, 1'b0, 9'h060},  // R6
        {3'd1, 10'd42,   8'h00, 1'b0, 1'b0, 9'h0A4},  // R6
        {3'd1, 10'd100,  8'h00, 1'b0, 1'b0, 9'h0A4},  // R7 out of range
        {3'd1, 10'd40,   8'h00, 1'b0, 1'b0, 9'h100},  // R6 empty
        {3'd1, 10'd40,   8'h00, 1'b0, 1'b0, 9'h100},  // R7 idle
        {3'd2, 10'd0,    8'h0F, 1'b0, 1'b0, 9'h100},  // R8 -> 7
        {3'd0, 10'd7,    8'h12, 1'b0, 1'b1, 9'h000},  // R2 bp7
        {3'd0, 10'd8,    8'h00, 1'b0, 1'b0, 9'h000},  // R4
        {3'd1, 10'd7,    8'h00, 1'b0, 1'b0, 9'h100},  // R6
        {3'd2, 10'd0,    8'h0A, 1'b0, 1'b0, 9'h100},  // R8 -> 2
        {3'd3, 10'd0,    8'h03, 1'b0, 1'b0, 9'h100},  // R8 -> 3
        {3'd0, 10'd9,    8'h3C, 1'b1, 1'b1, 9'h030},  // R3 alias
        {3'd1, 10'd9,    8'h00, 1'b0, 1'b0, 9'h100},
        {3'd4, 10'd0,    8'h01, 1'b0, 1'b0, 9'h100},
        {3'd0, 10'd9,    8'h3C, 1'b1, 1'b1, 9'h038},  // R3 common
        {3'd1, 10'd9,    8'h00, 1'b0, 1'b0, 9'h100},
        {3'd4, 10'd0,    8'h00, 1'b0, 1'b0, 9'h100},
        {3'd2, 10'd0,    8'h00, 1'b0, 1'b0, 9'h100},
        {3'd0, 10'd20,   8'h80, 1'b0, 1'b1, 9'h080},
        {3'd0, 10'd21,   8'h40, 1'b1, 1'b1, 9'h040},
        {3'd1, 10'd20,   8'h00, 1'b0, 1'b0, 9'h040},  // R6 group map only
        {3'd1, 10'd21,   8'h00, 1'b0, 1'b0, 9'h100}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic apply(input int op, input logic [9:0] id, input logic [7:0] data,
                         input logic grp);
        @(negedge clk);
        case (op)
            0: begin ack_req = 1'b1; ack_id = id; ack_prio = data; ack_grp = grp; end
            1: begin eoi_req = 1'b1; eoi_id = id; end
            2: begin bpr_we = 1'b1; bp_wdata = data; end
            3: begin abpr_we = 1'b1; bp_wdata = data; end
            default: cbpr_en = data[0];
        endcase
        @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0; bpr_we = 1'b0; abpr_we = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run", int'(run_prio), 'h100);
        chk("R1 bpr", int'(bpr_val), 0);
        chk("R1 abpr", int'(abpr_val), 1);
        chk("R1 active", int'(active != '0), 0);
        chk("R1 rsp", int'(rsp_valid), 0);

        for (int i = 0; i < NV; i++) begin
            apply(int'(VEC[i][31:29]), VEC[i][28:19], VEC[i][18:11], VEC[i][10]);
            chk($sformatf("R6 run vec%0d", i), int'(run_prio), int'(VEC[i][8:0]));
            if (VEC[i][31:29] == 3'd0) begin
                chk($sformatf("R10 valid vec%0d", i), int'(rsp_valid), 1);
                chk($sformatf("R4 grant vec%0d", i), int'(rsp_grant), int'(VEC[i][9]));
                chk($sformatf("R5 id vec%0d", i), int'(rsp_id),
                    VEC[i][9] ? int'(VEC[i][28:19]) : 1023);
            end
            if (i == 10) chk("R8 bpr low bits", int'(bpr_val), 7);
        end

        // R10 response is a single pulse
        @(negedge clk);
        chk("R10 pulse", int'(rsp_valid), 0);

        // R8 alias clamp to minimum
        apply(3, 10'd0, 8'h00, 1'b0);
        chk("R8 abpr clamp", int'(abpr_val), 1);

        // R5 active flag set and cleared
        apply(0, 10'd30, 8'h50, 1'b0);
        chk("R5 active set", int'(active[30]), 1);
        chk("R5 run", int'(run_prio), 'h50);

        // R9 simultaneous ack and eoi: ack wins
        @(negedge clk);
        ack_req = 1'b1; ack_id = 10'd31; ack_prio = 8'h10; ack_grp = 1'b0;
        eoi_req = 1'b1; eoi_id = 10'd30;
        @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0;
        chk("R9 run", int'(run_prio), 'h10);
        chk("R9 active kept", int'(active[30]), 1);
        chk("R9 active new", int'(active[31]), 1);

        apply(1, 10'd31, 8'h00, 1'b0);
        chk("R6 run after 31", int'(run_prio), 'h50);
        apply(1, 10'd30, 8'h00, 1'b0);
        chk("R6 run idle", int'(run_prio), 'h100);
        chk("R6 active cleared", int'(active[30]), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule